// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Programmer

This block burns a single 32-bit word of a one-time-programmable fuse array each time software asks it to. Software reaches it through three memory-mapped registers: a control register that holds the target word address, status flags and an arming key, a timing register that sets phase lengths in clock cycles, and a data register that holds the word to burn. Writing the data register starts the job, but only if the arming key was written into the control register beforehand. The key is used up by every start, so it has to be written again before each word.

Once a job starts, the block freezes a private copy of the word address. It reads the current fuse word and clears from the data every bit that is already blown. It then walks all 32 bit positions from bit 0 upward. For each remaining 1 bit it waits a relax period, pulses the program strobe for the programmed number of cycles, and waits a second relax period. The data register shifts right with zero fill as the walk goes on. After the busy flag drops, a fixed postamble delay must pass before another job can start. A start aimed at a locked word, or a start that was never armed, raises a sticky error flag and touches no fuse.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset every register reads zero. The control register is laid out as follows: bits [6:0] hold the word address, bit 8 is BUSY, bit 9 is ERROR, and bits [31:16] read 0x3E77 while the block is armed and 0 otherwise. All other bits read zero.
- R2: A control write (offset 0x00) whose bits [31:16] equal 0x3E77 arms the block, and a control write with any other value disarms it. Every data write made while the sequencer is idle disarms it, so the key must be written again before each start.
- R3: A data write (offset 0x20) starts a job when the block is armed, idle, has ERROR clear and the addressed word is not locked. BUSY is then set and the address is latched. Control address writes made during the job do not change the word being programmed.
- R4: A data write made while idle and not armed starts nothing and sets ERROR.
- R5: An armed start aimed at a locked word makes no fuse read and no strobe, leaves BUSY low, sets ERROR and leaves the fuse word unchanged.
- R6: ERROR is sticky and blocks every start. A control write with bit 9 set clears it.
- R7: A data write made while BUSY is set, or during the postamble, is ignored: it starts no new job, does not change the data being burned and does not set ERROR.
- R8: A job first asserts the fuse read for STROBE_READ cycles. It then drops from the data every bit that is already 1 in the fuse word, so strobes fire only for bits that are 1 in the data and 0 in the fuse.
- R9: For each bit that remains to be programmed, the block waits RELAX cycles, holds the program strobe for STROBE_PROG cycles, and waits RELAX cycles again. A field value of zero counts as one cycle. BUSY lasts STROBE_READ + 32 + k·(2·RELAX + STROBE_PROG) cycles, where k is the number of bits programmed.
- R10: The data register shifts right with zero fill, one position per bit visited, and reads zero when the job ends. The fuse word then equals its old value OR the data.
- R11: After BUSY falls, starts are refused for POST_CYCLES cycles, and the arming is kept. A start on the following cycle is accepted.
- R12: The timing register (offset 0x10) holds STROBE_PROG in bits [11:0], RELAX in bits [15:12] and STROBE_READ in bits [21:16]. Its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset (0x00 control, 0x10 timing, 0x20 data) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| fuse_addr | output | ADDR_W | Word address presented to the fuse array |
| fuse_rd_en | output | 1 | Fuse word read enable |
| fuse_rdata | input | 32 | Current contents of the addressed fuse word |
| fuse_locked | input | 1 | Addressed fuse word is write-locked |
| fuse_prog | output | 1 | Program strobe |
| fuse_bit | output | 5 | Bit position targeted by the strobe |

## Verification
The hardest case to reach from the ports is the exact edge of the postamble window. The bench watches for the first cycle in which BUSY reads low. It then places one armed data write on the last refused cycle and a second on the first cycle that should be accepted. It also checks that arming survives the refused attempt. A second hard case is a job that runs while software interferes with it. In that case the bench rewrites the control address and the data register in the middle of a burn, then checks the fuse model to confirm that only the original word received the original bits.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [OFS_W-1:0] OFS_TIMING = 6'h10;
  localparam logic [OFS_W-1:0] OFS_DATA = 6'h20;
  localparam logic [15:0] ARM_KEY = 16'h3E77;
  localparam int BUSY_POS = 8;
  localparam int ERR_POS = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_SCAN, ST_PRE, ST_STRB, ST_POSTR, ST_WAIT
  } seq_st_t;
endpackage

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              idle,
  input  logic              busy,
  input  logic              mask_en,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] fuse_rdata,
  input  logic              fuse_locked,
  output logic              start,
  output logic [ADDR_W-1:0] ctrl_addr,
  output logic              data_lsb,
  output logic [5:0]        tm_read,
  output logic [3:0]        tm_relax,
  output logic [11:0]       tm_prog
);
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              armed_q, armed_n;
  logic              err_q, err_n;
  logic [21:0]       tim_q, tim_n;
  logic [WORD_W-1:0] data_q, data_n;
  logic              wr_ctrl, wr_tim, wr_data, data_wr_idle;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_tim  = bus_wr && (bus_addr == OFS_TIMING);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign data_wr_idle = wr_data && idle;
  assign start = data_wr_idle && armed_q && !err_q && !fuse_locked;

  always_comb begin
    addr_n  = addr_q;
    armed_n = armed_q;
    err_n   = err_q;
    tim_n   = tim_q;
    data_n  = data_q;
    if (wr_ctrl) begin
      addr_n  = bus_wdata[ADDR_W-1:0];
      armed_n = (bus_wdata[31:16] == ARM_KEY);
      if (bus_wdata[ERR_POS]) err_n = 1'b0;
    end
    if (wr_tim) tim_n = bus_wdata[21:0];
    if (data_wr_idle) begin
      armed_n = 1'b0;
      data_n  = bus_wdata;
      if (!err_q && (!armed_q || fuse_locked)) err_n = 1'b1;
    end else if (mask_en) begin
      data_n = data_q & ~fuse_rdata;
    end else if (shift_en) begin
      data_n = {1'b0, data_q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
      tim_q   <= '0;
      data_q  <= '0;
    end else begin
      addr_q  <= addr_n;
      armed_q <= armed_n;
      err_q   <= err_n;
      tim_q   <= tim_n;
      data_q  <= data_n;
    end
  end

  assign ctrl_addr = addr_q;
  assign data_lsb  = data_q[0];
  assign tm_prog   = tim_q[11:0];
  assign tm_relax  = tim_q[15:12];
  assign tm_read   = tim_q[21:16];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[ADDR_W-1:0] = addr_q;
        bus_rdata[BUSY_POS]   = busy;
        bus_rdata[ERR_POS]    = err_q;
        bus_rdata[31:16]      = armed_q ? ARM_KEY : 16'h0000;
      end
      OFS_TIMING: bus_rdata[21:0] = tim_q;
      OFS_DATA:   bus_rdata = data_q;
      default:    bus_rdata = '0;
    endcase
  end

  // ERROR stays set until a control write with the clear bit
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_ctrl && bus_wdata[ERR_POS])) |=> err_q);

  // a job only begins from an armed, error-free state
  assert_start_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(armed_q) && !$past(err_q)));

  // bus writes to DATA never disturb the word while it is being burned
  assert_data_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_data && !mask_en && !shift_en) |=> $stable(data_q));
endmodule

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
  import otp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int POST_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ctrl_addr,
  input  logic              data_lsb,
  input  logic [5:0]        tm_read,
  input  logic [3:0]        tm_relax,
  input  logic [11:0]       tm_prog,
  output logic              idle,
  output logic              busy,
  output logic              mask_en,
  output logic              shift_en,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic              fuse_rd_en,
  output logic              fuse_prog,
  output logic [BIT_W-1:0]  fuse_bit
);
  localparam int POST_W = $clog2(POST_CYCLES + 2);
  localparam int CNT_W = (POST_W > 12) ? POST_W : 12;
  localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(WORD_W - 1);

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  seq_st_t           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BIT_W-1:0]  pos_q, pos_n;
  logic [ADDR_W-1:0] lat_q, lat_n;
  logic              last;
  logic [CNT_W-1:0]  len_read, len_relax, len_prog, len_post;

  assign len_read  = at_least_one(CNT_W'(tm_read));
  assign len_relax = at_least_one(CNT_W'(tm_relax));
  assign len_prog  = at_least_one(CNT_W'(tm_prog));
  assign len_post  = at_least_one(CNT_W'(POST_CYCLES));
  assign last = (cnt_q <= CNT_W'(1));

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    pos_n    = pos_q;
    lat_n    = lat_q;
    mask_en  = 1'b0;
    shift_en = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_n  = ST_READ;
        cnt_n = len_read;
        lat_n = ctrl_addr;
        pos_n = '0;
      end
      ST_READ: if (last) begin
        mask_en = 1'b1;
        st_n    = ST_SCAN;
      end else cnt_n = cnt_q - 1'b1;
      ST_SCAN: if (data_lsb) begin
        st_n  = ST_PRE;
        cnt_n = len_relax;
      end else begin
        shift_en = 1'b1;
        if (pos_q == LAST_POS) begin
          st_n  = ST_WAIT;
          cnt_n = len_post;
        end else pos_n = pos_q + 1'b1;
      end
      ST_PRE: if (last) begin
        st_n  = ST_STRB;
        cnt_n = len_prog;
      end else cnt_n = cnt_q - 1'b1;
      ST_STRB: if (last) begin
        st_n  = ST_POSTR;
        cnt_n = len_relax;
      end else cnt_n = cnt_q - 1'b1;
      ST_POSTR: if (last) begin
        shift_en = 1'b1;
        if (pos_q == LAST_POS) begin
          st_n  = ST_WAIT;
          cnt_n = len_post;
        end else begin
          pos_n = pos_q + 1'b1;
          st_n  = ST_SCAN;
        end
      end else cnt_n = cnt_q - 1'b1;
      ST_WAIT: if (last) st_n = ST_IDLE;
               else cnt_n = cnt_q - 1'b1;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      pos_q <= '0;
      lat_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      pos_q <= pos_n;
      lat_q <= lat_n;
    end
  end

  assign idle       = (st_q == ST_IDLE);
  assign busy       = (st_q != ST_IDLE) && (st_q != ST_WAIT);
  assign fuse_rd_en = (st_q == ST_READ);
  assign fuse_prog  = (st_q == ST_STRB);
  assign fuse_bit   = pos_q;
  assign fuse_addr  = idle ? ctrl_addr : lat_q;

  // checker state: length of the current program strobe
  logic [CNT_W-1:0] strb_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_len <= '0;
    else if (fuse_prog) strb_len <= strb_len + 1'b1;
    else strb_len <= '0;
  end

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fuse_addr));

  assert_strobe_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_prog) |-> (strb_len == len_prog));

  assert_no_start_in_post_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |=> !busy);

  assert_read_before_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_rd_en) |-> (st_q == ST_SCAN));
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int POST_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic              fuse_rd_en,
  input  logic [31:0]       fuse_rdata,
  input  logic              fuse_locked,
  output logic              fuse_prog,
  output logic [4:0]        fuse_bit
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              idle, busy, mask_en, shift_en, start, data_lsb;
  logic [ADDR_W-1:0] ctrl_addr;
  logic [5:0]        tm_read;
  logic [3:0]        tm_relax;
  logic [11:0]       tm_prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  otp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idle(idle), .busy(busy), .mask_en(mask_en), .shift_en(shift_en),
    .fuse_rdata(fuse_rdata), .fuse_locked(fuse_locked),
    .start(start), .ctrl_addr(ctrl_addr), .data_lsb(data_lsb),
    .tm_read(tm_read), .tm_relax(tm_relax), .tm_prog(tm_prog)
  );

  otp_seq_fsm #(.ADDR_W(ADDR_W), .POST_CYCLES(POST_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .start(start), .ctrl_addr(ctrl_addr), .data_lsb(data_lsb),
    .tm_read(tm_read), .tm_relax(tm_relax), .tm_prog(tm_prog),
    .idle(idle), .busy(busy), .mask_en(mask_en), .shift_en(shift_en),
    .fuse_addr(fuse_addr), .fuse_rd_en(fuse_rd_en), .fuse_prog(fuse_prog),
    .fuse_bit(fuse_bit)
  );
endmodule

// File: tb/otp_prog_seq_bench.sv
module otp_prog_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POST = 24;
  localparam logic [15:0] KEY = 16'h3E77;
  localparam int NV = 5;
  // {addr[7], old fuse[32], data[32], read[6], relax[4], prog[12]}
  localparam logic [92:0] VEC [NV] = '{
    {7'd3,   32'h0000_0000, 32'h0000_0001, 6'd2, 4'd1, 12'd4},
    {7'd10,  32'hF0F0_0000, 32'hFF00_00A5, 6'd3, 4'd2, 12'd5},
    {7'd127, 32'hFFFF_FFFF, 32'h1234_5678, 6'd1, 4'd1, 12'd1},
    {7'd0,   32'h0000_0000, 32'h8000_0000, 6'd0, 4'd0, 12'd0},
    {7'd64,  32'h0000_FFFF, 32'hFFFF_FFFF, 6'd4, 4'd1, 12'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [5:0] bus_addr = 6'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [6:0] fuse_addr;
  logic fuse_rd_en, fuse_prog;
  logic [4:0] fuse_bit;
  logic [31:0] fuse_rdata;
  logic fuse_locked;

  logic [31:0] fmem [128];
  logic [127:0] lock_mask = '0;
  int tests = 0, fails = 0;
  int exp_p = 1, run = 0, strobes = 0, bad_w = 0, rd_cycles = 0;
  logic [6:0] last_a;
  logic [4:0] last_b;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fuse_rdata = fmem[fuse_addr];
  assign fuse_locked = lock_mask[fuse_addr];

  otp_prog_seq #(.ADDR_W(7), .POST_CYCLES(POST)) u_otp_prog_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_addr(fuse_addr),
    .fuse_rd_en(fuse_rd_en), .fuse_rdata(fuse_rdata), .fuse_locked(fuse_locked),
    .fuse_prog(fuse_prog), .fuse_bit(fuse_bit)
  );

  // fuse array model: a strobe of the right width blows one bit
  always @(negedge clk) begin
    if (fuse_rd_en) rd_cycles++;
    if (fuse_prog) begin
      run++;
      last_a = fuse_addr;
      last_b = fuse_bit;
    end else if (run != 0) begin
      strobes++;
      if (run != exp_p) bad_w++;
      else fmem[last_a][last_b] = 1'b1;
      run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_now(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  function automatic int cl(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // count cycles with BUSY high, starting at the current negedge
  task automatic wait_busy(output int n);
    logic [31:0] c;
    n = 0;
    rd(6'h00, c);
    while (c[8] && n < 20000) begin
      n++;
      @(negedge clk);
      rd(6'h00, c);
    end
  endtask

  initial begin
    logic [31:0] v;
    int n, s0, r0;
    for (int i = 0; i < 128; i++) fmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(6'h00, v); chk(v == 32'h0, "R1 ctrl reset", v, 32'h0);
    rd(6'h10, v); chk(v == 32'h0, "R1 timing reset", v, 32'h0);
    rd(6'h20, v); chk(v == 32'h0, "R1 data reset", v, 32'h0);

    // R12: timing field layout
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, v); chk(v == 32'h003F_FFFF, "R12 timing readback", v, 32'h003F_FFFF);

    // R1 R2: arming readback and disarm
    wr(6'h00, {KEY, 16'h0005});
    rd(6'h00, v); chk(v == {KEY, 16'h0005}, "R2 armed readback", v, {KEY, 16'h0005});
    wr(6'h00, {16'h1234, 16'h0005});
    rd(6'h00, v); chk(v == 32'h0000_0005, "R2 disarm by wrong key", v, 32'h0000_0005);

    // main table
    for (int k = 0; k < NV; k++) begin
      logic [6:0] a; logic [31:0] old, dat; int sr, rl, pg, bits, eb;
      a = VEC[k][92:86]; old = VEC[k][85:54]; dat = VEC[k][53:22];
      sr = int'(VEC[k][21:16]); rl = int'(VEC[k][15:12]); pg = int'(VEC[k][11:0]);
      bits = $countones(dat & ~old);
      eb = cl(sr) + 32 + bits * (2 * cl(rl) + cl(pg));
      fmem[a] = old; exp_p = cl(pg); s0 = strobes; bad_w = 0;
      wr(6'h10, {10'h0, VEC[k][21:0]});
      wr(6'h00, {KEY, 9'h0, a});
      wr(6'h20, dat);
      wait_busy(n);
      chk(n == eb, "R9 busy length", n, eb);
      chk(strobes - s0 == bits, "R8 strobe count after masking", strobes - s0, bits);
      chk(bad_w == 0, "R9 strobe width", bad_w, 0);
      chk(fmem[a] == (old | dat), "R10 fuse result", fmem[a], old | dat);
      rd(6'h20, v); chk(v == 32'h0, "R10 data shifted out", v, 32'h0);
      rd(6'h00, v); chk(v[9] == 1'b0, "R3 no error", v, 32'h0);
      repeat (POST + 2) @(negedge clk);
    end

    // R4 R6: unarmed write errors, error blocks, clear restores
    wr(6'h10, 32'h0001_1001); exp_p = 1;
    wr(6'h00, 32'h0000_0008);
    wr(6'h20, 32'h1);
    rd(6'h00, v); chk(v[9] && !v[8], "R4 unarmed sets error", v, 32'h200);
    wr(6'h00, {KEY, 16'h0008});
    wr(6'h20, 32'h1);
    rd(6'h00, v); chk(v[9] && !v[8], "R6 error blocks start", v, 32'h200);
    wr(6'h00, {KEY, 16'h0208});
    rd(6'h00, v); chk(v == {KEY, 16'h0008}, "R6 clear keeps arm", v, {KEY, 16'h0008});
    wr(6'h20, 32'h0);
    rd(6'h00, v); chk(v[8] == 1'b1, "R6 start after clear", v, 32'h100);
    wait_busy(n);
    repeat (POST + 2) @(negedge clk);
    // R2: key consumed by the previous start
    wr(6'h20, 32'h0);
    rd(6'h00, v); chk(v[9] && !v[8], "R2 key consumed", v, 32'h200);
    wr(6'h00, 32'h0000_0200);

    // R5: locked word
    lock_mask[20] = 1'b1; fmem[20] = 32'h0; r0 = rd_cycles; s0 = strobes;
    wr(6'h00, {KEY, 16'h0014});
    wr(6'h20, 32'h0000_00FF);
    repeat (10) @(negedge clk);
    rd(6'h00, v); chk(v[9] && !v[8], "R5 locked sets error, no busy", v, 32'h214);
    chk(rd_cycles == r0 && strobes == s0, "R5 no fuse access", rd_cycles - r0, 0);
    chk(fmem[20] == 32'h0, "R5 word unchanged", fmem[20], 32'h0);
    wr(6'h00, 32'h0000_0200);

    // R3 R7: interference during a job
    fmem[30] = 0; fmem[31] = 0; exp_p = 3;
    wr(6'h10, 32'h0002_2003);
    wr(6'h00, {KEY, 16'h001E});
    wr(6'h20, 32'h0000_0003);
    wr(6'h00, 32'h0000_001F);
    wr(6'h20, 32'hFFFF_FFFF);
    wait_busy(n);
    chk(fmem[30] == 32'h3, "R7 data write ignored while busy", fmem[30], 32'h3);
    chk(fmem[31] == 32'h0, "R3 address latched", fmem[31], 32'h0);
    rd(6'h00, v); chk(v[9] == 1'b0, "R7 no error from busy write", v, 32'h0);

    // R11: postamble boundary (n0 = current negedge)
    wr_now(6'h00, {KEY, 16'h001E});
    repeat (POST - 2) @(negedge clk);
    wr_now(6'h20, 32'h0);
    rd(6'h00, v); chk(!v[8] && !v[9], "R11 refused in postamble", v, 32'h0);
    chk(v[31:16] == KEY, "R11 arming kept", v, {KEY, 16'h0});
    wr_now(6'h20, 32'h0);
    rd(6'h00, v); chk(v[8] == 1'b1, "R11 accepted after postamble", v, 32'h100);
    wait_busy(n);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule